// File: doc/BRIEF.md
# Token-Ring Round-Robin Bus Arbiter

This block shares one bus among four requesters. A one-hot token, kept in a small ring of flip-flops, names the requester that currently holds top priority. Four fixed-priority slices each see the request vector rotated so that it begins at a different requester. Only the slice whose index matches the set token bit is enabled. The enabled slice grants the first active requester found at or after the token position, wrapping past the last requester back to the first.

The grant is purely combinational from the requests and the current token. The token moves on to the next requester on every clock edge at which `ack` is high. It moves whichever requester won, and also when nobody was requesting. It holds still while `ack` is low. A bus master completing a transfer pulses `ack` for one cycle to pass priority along.

Top module: `tok_rr_arb`

## Requirements
- R1: While `rst_n` is low the token is forced to requester 0, so right after reset, with all four requests high, `grant` equals 4'b0001.
- R2: At most one bit of `grant` is ever set.
- R3: When `req` is all zeros, `grant` is all zeros.
- R4: A `grant` bit is set only when the matching `req` bit is set.
- R5: With the token at position p, `grant` has a single bit set at the first index i in the order p, p+1, ..., p+3 (mod 4) where `req[i]` is high. For example, with the token at 2 and only requesters 0 and 1 requesting, requester 0 wins.
- R6: On each rising clock edge where `ack` is high, the token moves from position p to (p+1) mod 4, independent of which requester held the grant. While `ack` is low the token keeps its position.
- R7: An `ack` with no request pending still advances the token by one position.
- R8: `grant` follows a change of `req` in the same cycle, without waiting for a clock edge.
- R9: The token wraps from position 3 to position 0 and is always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the token register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the token with requester 0 |
| req | input | 4 | Request vector, one bit per requester |
| ack | input | 1 | Pass priority on; advances the token one position |
| grant | output | 4 | One-hot-or-zero grant, combinational from `req` and the token |

## Verification
The checker tests several properties on every cycle: that the grant is one-hot-or-zero, that it stays inside the request set and is non-zero whenever a request is present, and that the token is the requester granted when that requester is asking. It also checks that the token stays one-hot, rotates by exactly one position on `ack`, and stays still without it. What the checker cannot show by itself is that the winner is the correct one in the wrapped search order for every token position and request pattern. The bench covers this with a full sweep of all 16 request patterns at each of the four positions, modelled arithmetically. The bench also covers the reset position, the same-cycle response to a request change, and rotation driven by `ack` alone with idle requesters.

// File: rtl/tok_rr_pkg.sv
package tok_rr_pkg;

  // Number of requesters the arbiter is built for by default.
  localparam int unsigned ARB_WIDTH_DEF = 4;

  // One-position left rotation of a one-hot priority vector.
  function automatic logic [ARB_WIDTH_DEF-1:0] rot_up(input logic [ARB_WIDTH_DEF-1:0] v);
    return {v[ARB_WIDTH_DEF-2:0], v[ARB_WIDTH_DEF-1]};
  endfunction

endpackage

// File: rtl/tok_rr_ring.sv
module tok_rr_ring #(
  parameter int unsigned WIDTH = tok_rr_pkg::ARB_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WIDTH-1:0] token
);

  localparam logic [WIDTH-1:0] TOKEN_RST = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] token_q;
  logic [WIDTH-1:0] token_d;

  // Next-state: rotate toward the next-higher requester index.
  always_comb begin
    token_d = {token_q[WIDTH-2:0], token_q[WIDTH-1]};
  end

  // Register with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      token_q <= TOKEN_RST;
    end else if (adv) begin
      token_q <= token_d;
    end
  end

  assign token = token_q;

endmodule

// File: rtl/tok_rr_slice.sv
module tok_rr_slice #(
  parameter int unsigned WIDTH = tok_rr_pkg::ARB_WIDTH_DEF
) (
  input  logic             en,
  input  logic [WIDTH-1:0] in_vec,
  output logic [WIDTH-1:0] out_vec
);

  // Fixed priority: lowest index of the rotated view wins, gated by en.
  always_comb begin
    logic seen;
    seen    = 1'b0;
    out_vec = '0;
    for (int j = 0; j < WIDTH; j++) begin
      out_vec[j] = en & in_vec[j] & ~seen;
      seen       = seen | in_vec[j];
    end
  end

endmodule

// File: rtl/tok_rr_arb.sv
module tok_rr_arb #(
  parameter int unsigned NREQ = tok_rr_pkg::ARB_WIDTH_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            ack,
  output logic [NREQ-1:0] grant
);

  logic [NREQ-1:0] token_w;
  logic [NREQ-1:0] rot_req   [NREQ];
  logic [NREQ-1:0] slice_out [NREQ];
  logic [NREQ-1:0] contrib   [NREQ];

  tok_rr_ring #(.WIDTH(NREQ)) ring_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (ack),
    .token (token_w)
  );

  // One slice per token position, each seeing requests from its start index.
  for (genvar k = 0; k < NREQ; k++) begin : g_slice
    for (genvar j = 0; j < NREQ; j++) begin : g_rot
      assign rot_req[k][j] = req[(k + j) % NREQ];
    end
    tok_rr_slice #(.WIDTH(NREQ)) slice_i (
      .en      (token_w[k]),
      .in_vec  (rot_req[k]),
      .out_vec (slice_out[k])
    );
  end

  // Route each slice output back to its absolute requester and OR them.
  for (genvar g = 0; g < NREQ; g++) begin : g_merge
    for (genvar k = 0; k < NREQ; k++) begin : g_src
      assign contrib[g][k] = slice_out[k][(g - k + NREQ) % NREQ];
    end
    assign grant[g] = |contrib[g];
  end

endmodule

// File: rtl/tok_rr_arb_chk.sv
module tok_rr_arb_chk #(
  parameter int unsigned NREQ = tok_rr_pkg::ARB_WIDTH_DEF
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req,
  input logic            ack,
  input logic [NREQ-1:0] grant,
  input logic [NREQ-1:0] token
);

  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (grant == '0)); // R3

  AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0)); // R4

  AST_BUSY_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0)); // R5

  AST_TOKEN_HOLDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((token & req) != '0) |-> (grant == token)); // R5

  AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (token == $past({token[NREQ-2:0], token[NREQ-1]}))); // R6

  AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(token)); // R6

  AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(token)); // R9

endmodule

bind tok_rr_arb tok_rr_arb_chk #(.NREQ(NREQ)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .ack   (ack),
  .grant (grant),
  .token (token_w)
);

// File: tb/tok_rr_arb_tb_top.sv
`timescale 1ns/1ps
module tok_rr_arb_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = 4'b0000;
  logic       ack = 1'b0;
  logic [3:0] grant;

  int n_chk  = 0;
  int n_fail = 0;
  int tok_pos = 0;   // bench model of the token position

  always #2 clk = ~clk;  // 4 ns period

  tok_rr_arb dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .ack   (ack),
    .grant (grant)
  );

  function automatic logic [3:0] exp_grant(input int pos, input logic [3:0] r);
    for (int j = 0; j < 4; j++) begin
      if (r[(pos + j) % 4]) return 4'(1 << ((pos + j) % 4));
    end
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (token %0d, req %b)", tag, act, exp, tok_pos, req);
    end
  endtask

  task automatic drive_req(input logic [3:0] r);
    @(negedge clk);
    req = r;
    #0.5;
  endtask

  task automatic pulse_ack(input logic [3:0] r);
    @(negedge clk);
    req = r;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    tok_pos = (tok_pos + 1) % 4;
  endtask

  initial begin
    #(4.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset position is requester 0
    drive_req(4'b1111);
    check("R1 reset token", grant, 4'b0001);

    // R5 example: token at 2, requesters 0 and 1 -> 0 wins
    pulse_ack(4'b1111);
    pulse_ack(4'b0000);
    drive_req(4'b0011);
    check("R5 wrap example", grant, exp_grant(tok_pos, 4'b0011));
    check("R5 wrap literal", grant, 4'b0001);

    // Full sweep: every request pattern at every token position
    for (int step = 0; step < 5; step++) begin
      for (int r = 0; r < 16; r++) begin
        drive_req(4'(r));
        if (r == 0) check("R3 idle", grant, 4'b0000);
        else        check("R5 sweep", grant, exp_grant(tok_pos, 4'(r)));
        check("R4 subset", grant & ~req, 4'b0000);
        check("R2 onehot0", 4'($countones(grant) > 1), 4'b0000);
      end
      // R6: advance with a requester that is not the winner's neighbour
      pulse_ack(4'(1 << ((tok_pos + 2) % 4)));
    end

    // R6: no ack keeps the token where it is
    drive_req(4'b1111);
    repeat (3) @(negedge clk);
    check("R6 hold", grant, 4'(1 << tok_pos));

    // R7: ack with nothing requested still rotates
    for (int i = 0; i < 3; i++) begin
      pulse_ack(4'b0000);
      drive_req(4'b1111);
      check("R7 idle ack", grant, 4'(1 << tok_pos));
    end

    // R9: wrap from position 3 to 0
    while (tok_pos != 3) pulse_ack(4'b1000);
    drive_req(4'b1111);
    check("R9 at 3", grant, 4'b1000);
    pulse_ack(4'b1000);
    drive_req(4'b1111);
    check("R9 wrap to 0", grant, 4'b0001);

    // R8: grant follows req with no clock edge in between
    @(posedge clk);
    #1 req = 4'b0100;
    #0.5 check("R8 comb a", grant, exp_grant(tok_pos, 4'b0100));
    req = 4'b0010;
    #0.5 check("R8 comb b", grant, exp_grant(tok_pos, 4'b0010));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule